// File: doc/BRIEF.md
# Dual-Mode Hardware Thread Issue Selector

This block decides, every clock cycle, which of `NUM_THREADS` hardware threads may issue an instruction. Each thread has its own program counter register, so moving between threads never saves or restores anything. The issuing thread's identifier and PC appear at the outputs. A write port lets the pipeline store the next PC of whichever thread issued in that cycle.

Two policies share the same state. In interleaved mode the selector rotates to another thread each cycle and passes over any thread that reports a stall of either kind. In switch-on-miss mode it stays with one thread. A short stall only pauses issue. A long stall, such as a miss to a lower memory level, moves issue to the next thread that is free of long stalls. That move then costs a fixed refill gap of `REFILL_CYC` cycles.

The controller has three states:
- `SEL_FINE`: interleaved issue.
- `SEL_COARSE_RUN`: a single thread issues.
- `SEL_REFILL`: the refill gap after a switch.

Its transitions are:
- FINE→COARSE_RUN when the mode input is high at a clock edge.
- COARSE_RUN→REFILL when the current thread has a long stall and another thread is free of long stalls.
- REFILL→COARSE_RUN when the gap counter expires.
- COARSE_RUN or REFILL→FINE when the mode input is low at a clock edge.

Top module: `mt_thread_sel`

## Requirements
- R1: At reset the PC of thread t is t × `BOOT_STRIDE` (0x1000 by default), and the state is `SEL_FINE` with the rotation pointer on the last thread. The first cycle after reset with all threads ready therefore issues thread 0 with PC 0.
- R2: In interleaved mode with every thread ready, successive cycles issue threads 0, 1, 2, 3, 0, … in round-robin order, starting after the last issued thread.
- R3: In interleaved mode a thread whose `stall_i` bit or `long_stall_i` bit is 1 is skipped, and the next ready thread in rotation order issues in its place.
- R4: When no thread is ready, `issue_valid_o` is 0 and the rotation pointer is unchanged. The next issue is the thread following the last one that issued.
- R5: In switch-on-miss mode the current thread keeps issuing every cycle while it has no stall.
- R6: In switch-on-miss mode a short stall (`stall_i` bit 1, `long_stall_i` bit 0) on the current thread drops `issue_valid_o` for that cycle and causes no switch.
- R7: In switch-on-miss mode a long stall on the current thread selects the next thread in rotation order that has no long stall. `issue_valid_o` is 0 in the detection cycle and in the `REFILL_CYC` cycles after it (default 2). The new thread issues `REFILL_CYC`+1 cycles after detection.
- R8: In switch-on-miss mode, if every thread has a long stall, no switch and no refill gap occur. The current thread issues again as soon as its stall clears.
- R9: When `pc_wr_en_i` is 1 at an edge, `pc_wr_data_i` is written only to the thread that issued in that cycle. The write is ignored when `issue_valid_o` is 0, and the PCs of other threads are unchanged.
- R10: `coarse_mode_i` (1 = switch-on-miss, 0 = interleaved) is sampled at a clock edge and takes effect in the following cycle. No PC changes because of a mode change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| coarse_mode_i | input | 1 | 1 = switch-on-miss, 0 = interleaved |
| stall_i | input | NUM_THREADS | Per-thread short stall |
| long_stall_i | input | NUM_THREADS | Per-thread long stall |
| pc_wr_en_i | input | 1 | Write the issuing thread's PC |
| pc_wr_data_i | input | PC_W | New PC value |
| issue_valid_o | output | 1 | A thread issues this cycle |
| issue_tid_o | output | $clog2(NUM_THREADS) | Selected thread |
| issue_pc_o | output | PC_W | PC of the selected thread |

## Verification
The outputs are combinational from the registered state and the current stall inputs, so each issue result belongs to the same cycle in which its stimulus is driven. State effects such as pointer motion, PC writes and mode changes appear one edge later. The refill gap ends `REFILL_CYC`+1 cycles after a long stall is seen. The driver applies inputs at the falling edge and queues the expected result for that cycle. The monitor pops and compares 1 ns later, after the rising edge that consumed the previous cycle's inputs. Every delayed effect is therefore checked on the cycle where the requirement places it.

// File: rtl/mt_sel_pkg.sv
package mt_sel_pkg;
    typedef enum logic [1:0] {
        SEL_FINE       = 2'd0,
        SEL_COARSE_RUN = 2'd1,
        SEL_REFILL     = 2'd2
    } sel_state_e;
endpackage

// File: rtl/mt_rr_pick.sv
// Round-robin finder: first requester after 'base', wrapping, base itself last.
module mt_rr_pick #(
    parameter int N   = 4,
    parameter int IDW = $clog2(N)
) (
    input  logic [N-1:0]   req,
    input  logic [IDW-1:0] base,
    output logic           found,
    output logic [IDW-1:0] pick
);
    int             idx;
    logic [IDW-1:0] slot;

    always_comb begin
        found = 1'b0;
        pick  = '0;
        idx   = 0;
        slot  = '0;
        // descending so the nearest offset is the last to win
        for (int k = N; k >= 1; k--) begin
            idx = int'(base) + k;
            if (idx >= N) idx = idx - N;
            slot = IDW'(idx);
            if (req[slot]) begin
                found = 1'b1;
                pick  = slot;
            end
        end
    end
endmodule

// File: rtl/mt_pc_bank.sv
// Replicated per-thread PC registers with one write and one read port.
module mt_pc_bank #(
    parameter int N           = 4,
    parameter int PC_W        = 32,
    parameter int BOOT_STRIDE = 'h1000,
    parameter int IDW         = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [IDW-1:0]  wtid,
    input  logic [PC_W-1:0] wdata,
    input  logic [IDW-1:0]  rtid,
    output logic [PC_W-1:0] rdata
);
    logic [PC_W-1:0] pc_q [N];

    for (genvar t = 0; t < N; t++) begin : g_pc
        localparam logic [PC_W-1:0] BOOT_PC = PC_W'(BOOT_STRIDE * t);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         pc_q[t] <= BOOT_PC;
            else if (we && wtid == IDW'(t))     pc_q[t] <= wdata;
        end

        // R9: a thread not addressed by the write keeps its PC
        assert_other_pc_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && wtid == IDW'(t)) |=> $stable(pc_q[t]));
    end

    assign rdata = pc_q[rtid];
endmodule

// File: rtl/mt_thread_sel.sv
module mt_thread_sel
    import mt_sel_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int PC_W        = 32,
    parameter int REFILL_CYC  = 2,      // must be >= 1
    parameter int BOOT_STRIDE = 'h1000
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           coarse_mode_i,
    input  logic [NUM_THREADS-1:0]         stall_i,
    input  logic [NUM_THREADS-1:0]         long_stall_i,
    input  logic                           pc_wr_en_i,
    input  logic [PC_W-1:0]                pc_wr_data_i,
    output logic                           issue_valid_o,
    output logic [$clog2(NUM_THREADS)-1:0] issue_tid_o,
    output logic [PC_W-1:0]                issue_pc_o
);
    localparam int IDW = $clog2(NUM_THREADS);
    localparam int CW  = $clog2(REFILL_CYC + 1);

    sel_state_e     state_q, state_d;
    logic [IDW-1:0] cur_q, cur_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    logic [NUM_THREADS-1:0] ready_v;
    logic                   fine_found, coarse_found;
    logic [IDW-1:0]         fine_tid, coarse_tid;

    assign ready_v = ~(stall_i | long_stall_i);

    mt_rr_pick #(.N(NUM_THREADS), .IDW(IDW)) u_fine_pick (
        .req(ready_v), .base(cur_q), .found(fine_found), .pick(fine_tid));

    mt_rr_pick #(.N(NUM_THREADS), .IDW(IDW)) u_coarse_pick (
        .req(~long_stall_i), .base(cur_q), .found(coarse_found), .pick(coarse_tid));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEL_FINE;
            cur_q   <= IDW'(NUM_THREADS - 1);
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            cnt_q   <= cnt_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SEL_FINE: begin
                if (fine_found) cur_d = fine_tid;
                state_d = coarse_mode_i ? SEL_COARSE_RUN : SEL_FINE;
            end
            SEL_COARSE_RUN: begin
                if (!coarse_mode_i) begin
                    state_d = SEL_FINE;
                end else if (long_stall_i[cur_q] && coarse_found) begin
                    cur_d   = coarse_tid;
                    cnt_d   = CW'(REFILL_CYC);
                    state_d = SEL_REFILL;
                end
            end
            SEL_REFILL: begin
                if (!coarse_mode_i)          state_d = SEL_FINE;
                else if (cnt_q == CW'(1))    state_d = SEL_COARSE_RUN;
                else                         cnt_d   = cnt_q - CW'(1);
            end
            default: state_d = SEL_FINE;
        endcase
    end

    // outputs
    always_comb begin
        issue_valid_o = 1'b0;
        issue_tid_o   = cur_q;
        unique case (state_q)
            SEL_FINE: begin
                issue_valid_o = fine_found;
                issue_tid_o   = fine_tid;
            end
            SEL_COARSE_RUN: issue_valid_o = ready_v[cur_q];
            SEL_REFILL:     issue_valid_o = 1'b0;
            default:        issue_valid_o = 1'b0;
        endcase
    end

    mt_pc_bank #(.N(NUM_THREADS), .PC_W(PC_W), .BOOT_STRIDE(BOOT_STRIDE), .IDW(IDW)) u_pcs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (issue_valid_o && pc_wr_en_i),
        .wtid  (issue_tid_o),
        .wdata (pc_wr_data_i),
        .rtid  (issue_tid_o),
        .rdata (issue_pc_o)
    );

    // R3: interleaved issue never picks a stalled thread
    assert_fine_skips_stalled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEL_FINE && issue_valid_o) |->
            (!stall_i[issue_tid_o] && !long_stall_i[issue_tid_o]));

    // R4: idle interleaved cycle leaves the rotation pointer alone
    assert_idle_ptr_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEL_FINE && !issue_valid_o) |=> (cur_q == $past(cur_q)));

    // R6: short stall in switch-on-miss mode keeps the same thread
    assert_short_stall_no_switch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEL_COARSE_RUN && coarse_mode_i && !long_stall_i[cur_q]) |=>
            (cur_q == $past(cur_q) && state_q == SEL_COARSE_RUN));

    // R7: no issue during the refill gap
    assert_refill_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEL_REFILL) |-> !issue_valid_o);

    // R8: no candidate means no switch
    assert_no_candidate_stay_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEL_COARSE_RUN && coarse_mode_i && (&long_stall_i)) |=>
            (state_q == SEL_COARSE_RUN && cur_q == $past(cur_q)));
endmodule

// File: tb/mt_thread_sel_tb_top.sv
module mt_thread_sel_tb_top;
    localparam int T = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        coarse_mode_i = 1'b0;
    logic [T-1:0] stall_i = '1;
    logic [T-1:0] long_stall_i = '0;
    logic        pc_wr_en_i = 1'b0;
    logic [31:0] pc_wr_data_i = '0;
    logic        issue_valid_o;
    logic [1:0]  issue_tid_o;
    logic [31:0] issue_pc_o;

    always #2 clk = ~clk;   // 250 MHz

    mt_thread_sel dut_i (
        .clk(clk), .rst_n(rst_n), .coarse_mode_i(coarse_mode_i),
        .stall_i(stall_i), .long_stall_i(long_stall_i),
        .pc_wr_en_i(pc_wr_en_i), .pc_wr_data_i(pc_wr_data_i),
        .issue_valid_o(issue_valid_o), .issue_tid_o(issue_tid_o),
        .issue_pc_o(issue_pc_o));

    typedef struct {
        bit          v;
        int          tid;
        logic [31:0] pc;
        string       rq;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    // driver: apply one cycle of stimulus and queue the expected result
    task automatic step(input bit mode, input logic [T-1:0] st, input logic [T-1:0] ls,
                        input bit we, input logic [31:0] wd,
                        input bit ev, input int et, input logic [31:0] ep, input string rq);
        exp_t e;
        @(negedge clk);
        coarse_mode_i = mode;
        stall_i       = st;
        long_stall_i  = ls;
        pc_wr_en_i    = we;
        pc_wr_data_i  = wd;
        e.v = ev; e.tid = et; e.pc = ep; e.rq = rq;
        exp_q.push_back(e);
    endtask

    // monitor: compare after outputs settle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (issue_valid_o !== e.v) begin
                    errors++;
                    $display("FAIL %s valid got %0b exp %0b", e.rq, issue_valid_o, e.v);
                end else if (e.v && (int'(issue_tid_o) != e.tid || issue_pc_o !== e.pc)) begin
                    errors++;
                    $display("FAIL %s tid/pc got %0d/%h exp %0d/%h",
                             e.rq, issue_tid_o, issue_pc_o, e.tid, e.pc);
                end
            end
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // interleaved mode
        step(0, 4'h0, 4'h0, 1, 32'h10,   1, 0, 32'h0,    "R1 reset issue");
        step(0, 4'h0, 4'h0, 1, 32'h1010, 1, 1, 32'h1000, "R2 rotate t1");
        step(0, 4'h0, 4'h0, 0, 32'h0,    1, 2, 32'h2000, "R2 rotate t2");
        step(0, 4'h0, 4'h0, 0, 32'h0,    1, 3, 32'h3000, "R2 rotate t3");
        step(0, 4'h0, 4'h0, 0, 32'h0,    1, 0, 32'h10,   "R9 written pc t0");
        step(0, 4'h2, 4'h0, 0, 32'h0,    1, 2, 32'h2000, "R3 skip short stall");
        step(0, 4'h0, 4'h8, 0, 32'h0,    1, 0, 32'h10,   "R3 skip long stall");
        step(0, 4'hF, 4'h0, 1, 32'hDEAD, 0, 0, 32'h0,    "R4 all stalled");
        step(0, 4'hF, 4'h0, 0, 32'h0,    0, 0, 32'h0,    "R4 all stalled again");
        step(0, 4'h0, 4'h0, 0, 32'h0,    1, 1, 32'h1010, "R4 pointer kept");
        // mode input raised: still interleaved this cycle
        step(1, 4'h0, 4'h0, 0, 32'h0,    1, 2, 32'h2000, "R10 mode delayed");
        step(1, 4'h0, 4'h0, 1, 32'h2004, 1, 2, 32'h2000, "R5 stay on t2");
        step(1, 4'h0, 4'h0, 1, 32'h2008, 1, 2, 32'h2004, "R5 stay on t2 / R9");
        step(1, 4'h4, 4'h0, 1, 32'h2BAD, 0, 0, 32'h0,    "R6 short stall pauses");
        step(1, 4'h0, 4'h0, 0, 32'h0,    1, 2, 32'h2008, "R6 no switch / R9 ignored");
        step(1, 4'h0, 4'hC, 0, 32'h0,    0, 0, 32'h0,    "R7 detect long stall");
        step(1, 4'h0, 4'h0, 0, 32'h0,    0, 0, 32'h0,    "R7 refill 1");
        step(1, 4'h0, 4'h0, 0, 32'h0,    0, 0, 32'h0,    "R7 refill 2");
        step(1, 4'h0, 4'h0, 0, 32'h0,    1, 0, 32'h10,   "R7 switched to t0");
        step(1, 4'h0, 4'hF, 0, 32'h0,    0, 0, 32'h0,    "R8 all long stalled");
        step(1, 4'h0, 4'h0, 0, 32'h0,    1, 0, 32'h10,   "R8 no switch no gap");
        // mode input lowered: still switch-on-miss this cycle
        step(0, 4'h0, 4'h0, 0, 32'h0,    1, 0, 32'h10,   "R10 mode delayed back");
        step(0, 4'h0, 4'h0, 0, 32'h0,    1, 1, 32'h1010, "R10 interleave t1");
        step(0, 4'h0, 4'h0, 0, 32'h0,    1, 2, 32'h2008, "R10 pc kept t2");
        step(0, 4'h0, 4'h0, 0, 32'h0,    1, 3, 32'h3000, "R10 pc kept t3");
        @(negedge clk);
        #3;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule